// File: doc/BRIEF.md
# Sequential Keypad Code Lock

This block is a combination lock for a keypad. Each key press arrives as a single-cycle strobe that carries a key index. A one-hot position register marks which digit of a fixed code the lock expects next. Only that position's stored digit is compared with the incoming key. A key that matches moves the marker one place forward. Any other key sends the marker back to the first place.

When every digit of the code has been entered in order, the marker reaches an extra final place, and the unlock output goes high. It stays high until the next strobe. That strobe relocks the lock whatever its value, and it does not count as the first digit of a new attempt.

The code length and the code are parameters. Keypad scanning and debouncing are left to the logic that produces the strobes, which must be clean, synchronous single-cycle events.

Top module: `keycode_lock`

## Requirements
- R1: While `rst_n` is low and after its release with no strobe, `position` equals 1 (bit 0 set) and `unlocked` is 0.
- R2: After reset, exactly one bit of `position` is set in every cycle.
- R3: A strobe whose key equals the digit expected at the current locked position moves the set bit of `position` up by one on the next clock edge.
- R4: A strobe whose key differs from the expected digit, at any locked position, sets `position` to 1 on the next edge. This holds even when the key equals the first code digit.
- R5: After `DIGITS` consecutive correct strobes, `position` has only bit `DIGITS` set and `unlocked` is 1.
- R6: While unlocked, a strobe with any key value sets `position` to 1 and `unlocked` to 0. That strobe is not taken as the first digit of a new attempt.
- R7: In a cycle without a strobe, `position` and `unlocked` hold their values.
- R8: Strobes presented while `rst_n` is low have no effect, and the lock leaves reset at position 1.
- R9: The code digit expected at position i is `CODE[i*KEY_W +: KEY_W]`, so digit 0 sits in the least significant field and is entered first. Entering the digits in any other order does not unlock.
- R10: The correct key always advances the lock and never resets it. A wrong key can only reset it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_vld | input | 1 | Single-cycle key strobe |
| key_idx | input | KEY_W | Index of the pressed key, valid with `key_vld` |
| position | output | DIGITS+1 | One-hot progress marker; bit `DIGITS` means open |
| unlocked | output | 1 | High while the full code has been accepted |

## Verification
The bench builds the lock with its default shape: four digits, 4-bit key indices, and code 3, 7, 1, 9 in entry order. With sixteen possible keys, every wrong key can be tried at every one of the four positions, and every key value can be tried as the relocking press. That includes the corner where a wrong key equals the first code digit. The expected position is computed in the bench from the code digits. The bench also covers a reversed entry order, idle cycles in mid-sequence, and strobes held during reset.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    localparam int KL_MAX_DIGITS = 8;

    // Outcome of one cycle, chosen by the next-state logic.
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_ADVANCE = 2'd1,
        EV_MISS    = 2'd2,
        EV_RELOCK  = 2'd3
    } kl_event_e;

endpackage

// File: rtl/keylock_match.sv
module keylock_match #(
    parameter int                  DIGITS = 4,
    parameter int                  KEY_W  = 4,
    parameter logic [8*KEY_W-1:0]  CODE   = '0
) (
    input  logic [DIGITS-1:0] armed,
    input  logic [KEY_W-1:0]  key,
    output logic              hit
);

    logic [DIGITS-1:0] sel;

    // Each armed position compares the key with its own stored digit.
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        assign sel[i] = armed[i] && (key == CODE[i*KEY_W +: KEY_W]);
    end

    assign hit = |sel;

endmodule

// File: rtl/keylock_seq.sv
module keylock_seq
    import keylock_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            key_vld,
    input  logic            hit,
    output logic [DIGITS:0] pos_q,
    output kl_event_e       evt
);

    localparam int POS_W = DIGITS + 1;
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } seq_state_t;

    seq_state_t state_d, state_q;
    kl_event_e  evt_d;

    always_comb begin
        state_d = state_q;
        evt_d   = EV_IDLE;
        if (key_vld) begin
            if (state_q.pos[DIGITS]) begin
                state_d.pos = POS_FIRST;
                evt_d       = EV_RELOCK;
            end else if (hit) begin
                state_d.pos = state_q.pos << 1;
                evt_d       = EV_ADVANCE;
            end else begin
                state_d.pos = POS_FIRST;
                evt_d       = EV_MISS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pos <= POS_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    assign pos_q = state_q.pos;
    assign evt   = evt_d;

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pos_q) == 1); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_vld |=> $stable(pos_q)); // R7
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld && hit |=> !pos_q[0] && $countones(pos_q) == 1); // R10
    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld && !hit |=> pos_q == POS_FIRST); // R4
    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld && pos_q[DIGITS] |=> !pos_q[DIGITS]); // R6

endmodule

// File: rtl/keycode_lock.sv
module keycode_lock
    import keylock_pkg::*;
#(
    parameter int                 DIGITS = 4,
    parameter int                 KEY_W  = 4,
    parameter logic [8*KEY_W-1:0] CODE   = 'h9173
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_vld,
    input  logic [KEY_W-1:0]  key_idx,
    output logic [DIGITS:0]   position,
    output logic              unlocked
);

    if (DIGITS < 1 || DIGITS > KL_MAX_DIGITS) begin : g_bad_len
        $error("keycode_lock: DIGITS out of range");
    end

    logic      hit;
    logic      prev_unlocked;
    kl_event_e evt;

    keylock_match #(
        .DIGITS (DIGITS),
        .KEY_W  (KEY_W),
        .CODE   (CODE)
    ) u_match (
        .armed (position[DIGITS-1:0]),
        .key   (key_idx),
        .hit   (hit)
    );

    keylock_seq #(
        .DIGITS (DIGITS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_vld (key_vld),
        .hit     (hit),
        .pos_q   (position),
        .evt     (evt)
    );

    assign unlocked = position[DIGITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_unlocked <= 1'b0;
        else        prev_unlocked <= unlocked;
    end

    AST_OPEN_NEEDS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(evt) == EV_ADVANCE); // R5
    AST_NO_HIT_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> !hit); // R6
    AST_OPEN_DROPS_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        prev_unlocked && !unlocked |-> $past(key_vld)); // R7

endmodule

// File: tb/keycode_lock_test.sv
`timescale 1ns/1ps
module keycode_lock_test;

    localparam int          DIGITS = 4;
    localparam int          KEY_W  = 4;
    localparam logic [31:0] CODE   = 32'h9173;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              key_vld = 1'b0;
    logic [KEY_W-1:0]  key_idx = '0;
    logic [DIGITS:0]   position;
    logic              unlocked;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    keycode_lock #(.DIGITS(DIGITS), .KEY_W(KEY_W), .CODE(CODE)) uut (
        .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_idx(key_idx),
        .position(position), .unlocked(unlocked)
    );

    function automatic logic [KEY_W-1:0] digit(int i);
        return KEY_W'((CODE >> (KEY_W*i)) & 32'hF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one strobe; sample on the following falling edge.
    task automatic press(logic [KEY_W-1:0] k);
        @(negedge clk);
        key_idx = k;
        key_vld = 1'b1;
        @(negedge clk);
        key_vld = 1'b0;
    endtask

    task automatic enter_code();
        for (int i = 0; i < DIGITS; i++) begin
            press(digit(i));
            chk("R3", 32'(position), 32'(1) << (i + 1));
        end
    endtask

    initial begin
        // R8: strobes held during reset are ignored
        key_vld = 1'b1;
        key_idx = digit(0);
        repeat (3) @(negedge clk);
        chk("R1", 32'(position), 32'd1);
        chk("R1", 32'(unlocked), 32'd0);
        key_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", 32'(position), 32'd1);

        // R4: every wrong key at every locked position
        for (int p = 0; p < DIGITS; p++) begin
            for (int k = 0; k < 16; k++) begin
                if (KEY_W'(k) != digit(p)) begin
                    for (int i = 0; i < p; i++) begin
                        press(digit(i));
                        chk("R3", 32'(position), 32'(1) << (i + 1));
                    end
                    press(KEY_W'(k));
                    chk("R4", 32'(position), 32'd1);
                    chk("R4", 32'(unlocked), 32'd0);
                end
            end
        end

        // R7: idle cycles in mid-sequence hold the state
        press(digit(0));
        press(digit(1));
        repeat (5) @(negedge clk);
        chk("R7", 32'(position), 32'd4);
        press(digit(2));
        press(digit(3));
        chk("R5", 32'(position), 32'(1) << DIGITS);
        chk("R5", 32'(unlocked), 32'd1);
        repeat (4) @(negedge clk);
        chk("R7", 32'(unlocked), 32'd1);

        // R6: any key relocks, and it does not count as digit 0
        for (int k = 0; k < 16; k++) begin
            press(KEY_W'(k));
            chk("R6", 32'(position), 32'd1);
            chk("R6", 32'(unlocked), 32'd0);
            enter_code();
            chk("R5", 32'(unlocked), 32'd1);
        end
        press(digit(0));
        chk("R6", 32'(position), 32'd1);
        press(digit(0));
        chk("R10", 32'(position), 32'd2);

        // R9: reversed order must not open
        press(4'hE);
        for (int i = DIGITS - 1; i >= 0; i--) press(digit(i));
        chk("R9", 32'(unlocked), 32'd0);
        press(4'hE);
        enter_code();
        chk("R9", 32'(unlocked), 32'd1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule